// File: doc/BRIEF.md
# I2C Host Serial Clock Phase Generator

This block produces the serial clock of an I2C host. A prescaler divides the system clock by a programmable baud value plus one, giving a slow tick. Every SCL period is a fixed series of such ticks: the line is pulled low, the low level is checked, the line is let go, and a high level is then confirmed on one or more ticks. A fast-mode bit picks between a five-tick period and a four-tick period.

A client that holds SCL low (clock stretching) makes the high phase longer. The block keeps sampling on every tick until it sees the line high, then it needs extra high samples before it ends the period. The SCL pin is open-drain: the block only asserts a pull-low enable. A one-cycle strobe marks the end of each period, so a byte engine can step on it. A one-cycle fault pulse reports a line that failed to go low. START and STOP conditions, data shifting and arbitration belong to other blocks.

All pins are plain control and status signals. No data stream crosses the boundary, so the block has no valid/ready handshake and no back-pressure.

Top module: `scl_phase_gen`

## Requirements
- R1: While running, the prescaled tick occurs once every baud+1 clock cycles, and the baud value is 8 bits wide.
- R2: With baud ≥ 1 and no stretching, a period lasts 5 ticks when fast_mode is 0 and 4 ticks when fast_mode is 1. That is 5·(baud+1) or 4·(baud+1) clock cycles between period_done strobes.
- R3: scl_pull is asserted for exactly the first two ticks of every period (drive-low, then verify-low), which is 2·(baud+1) cycles. It is deasserted for the rest of the period.
- R4: scl_in passes through a two-flop synchronizer. If a high-confirm tick samples the line low, that tick is followed by further ticks until a high sample is seen. After that first high sample, 2 more high samples are required (fast_mode 0) or 1 more (fast_mode 1). If the line becomes high S cycles after release, the high phase needs m ticks, where m = max(1, ceil((S+3)/(baud+1)) − 1). The high phase then lasts the nominal count when m = 1, or m + 2 (fast 0) / m + 1 (fast 1) ticks when m > 1.
- R5: If the synchronized line reads high on the verify-low tick, low_fault pulses for one cycle. The line is still released on the next tick, and the period keeps its normal length.
- R6: period_done is a one-cycle pulse on the last high-confirm tick, with scl_pull deasserted. In the next cycle scl_pull is asserted to start the next period.
- R7: One cycle after enable goes low, scl_pull, period_done and low_fault are 0 and stay 0. When enable returns, the prescaler and phase restart, so the first period_done appears exactly one nominal period after the first running cycle.
- R8: During and after reset with enable low, scl_pull, period_done and low_fault are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run request; low holds the block released and idle |
| baud | input | 8 | Prescaler value; tick period is baud+1 clocks |
| fast_mode | input | 1 | 1 selects the four-tick period, 0 the five-tick period |
| scl_in | input | 1 | SCL line level as read from the pad (asynchronous) |
| scl_pull | output | 1 | Open-drain pull-low enable for SCL |
| period_done | output | 1 | One-cycle strobe at the end of each SCL period |
| low_fault | output | 1 | One-cycle pulse when SCL was not low on the verify tick |

## Verification
The in-line assertions check on every cycle that the tick spacing follows the baud value, that the outputs stay quiet while stopped, that a fault can only occur while the line is pulled, that the end strobe falls in the released phase, and that the high-sample counter stays in range. Only the bench scenarios can show the whole-period lengths under several baud, fast-mode and stretch combinations. They also show the exact stretch extension after synchronizer latency, the fault behaviour of a line stuck high, and the clean restart after a disable in the middle of a period.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  typedef enum logic [1:0] {
    PH_DRIVE   = 2'd0,
    PH_VERIFY  = 2'd1,
    PH_RELEASE = 2'd2,
    PH_HIGH    = 2'd3
  } scl_phase_e;

  localparam int unsigned HIGH_SAMPLES_STD  = 2;
  localparam int unsigned HIGH_SAMPLES_FAST = 1;
  localparam int unsigned HC_W = $clog2(HIGH_SAMPLES_STD + 2);
endpackage

// File: rtl/scl_sync.sv
module scl_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b1;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
  parameter int unsigned BAUD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [BAUD_W-1:0] baud,
  output logic              tick
);
  logic [BAUD_W-1:0] cnt;
  logic              wrap;

  assign wrap = (cnt >= baud);
  assign tick = run && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (!run)  cnt <= '0;
    else if (wrap)  cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end

  // R1: with a nonzero, unchanged baud value two ticks never sit back to back
  a_r1_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && baud != '0) |=> (!tick || baud != $past(baud)));
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import scl_gen_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic tick,
  input  logic fast_mode,
  input  logic scl_s,
  output logic run,
  output logic pull,
  output logic done,
  output logic fault
);
  scl_phase_e      st;
  logic [HC_W-1:0] hc;
  logic [HC_W-1:0] hc_nxt;
  logic [HC_W-1:0] need;
  logic            stretched;
  logic            last_high;

  assign need      = (fast_mode ? HC_W'(HIGH_SAMPLES_FAST) : HC_W'(HIGH_SAMPLES_STD))
                     + HC_W'(stretched);
  assign hc_nxt    = hc + 1'b1;
  assign last_high = scl_s && (hc_nxt == need);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= 1'b0;
    else        run <= enable;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= PH_DRIVE;
      hc        <= '0;
      stretched <= 1'b0;
    end else if (!run) begin
      st        <= PH_DRIVE;
      hc        <= '0;
      stretched <= 1'b0;
    end else if (tick) begin
      unique case (st)
        PH_DRIVE:   st <= PH_VERIFY;
        PH_VERIFY:  st <= PH_RELEASE;
        PH_RELEASE: begin
          st        <= PH_HIGH;
          hc        <= '0;
          stretched <= 1'b0;
        end
        PH_HIGH: begin
          if (!scl_s) begin
            stretched <= 1'b1;
            hc        <= '0;
          end else if (last_high) begin
            st        <= PH_DRIVE;
            hc        <= '0;
            stretched <= 1'b0;
          end else begin
            hc <= hc_nxt;
          end
        end
        default: st <= PH_DRIVE;
      endcase
    end
  end

  assign pull  = run && (st == PH_DRIVE || st == PH_VERIFY);
  assign fault = run && tick && (st == PH_VERIFY) && scl_s;
  assign done  = run && tick && (st == PH_HIGH) && last_high;

  // R7: a stopped block neither pulls the line nor strobes
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!pull && !done && !fault));
  // R3: a new low phase begins only after a period end or at start-up
  a_r3_pull_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pull) |-> ($past(done) || $rose(run)));
  // R3: the line is let go only on a tick (or on stop)
  a_r3_release_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pull) && run) |-> $past(tick));
  // R5: a fault is reported while the line is still being pulled
  a_r5_fault_while_low: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> pull);
  // R6: the end strobe falls in the released phase and is followed by a pull
  a_r6_done_released: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!pull && tick));
  a_r6_done_then_pull: assert property (@(posedge clk) disable iff (!rst_n)
    (done && enable) |=> (pull && !done));
  // R4: the high-sample counter never exceeds the stretched requirement
  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    hc <= HC_W'(HIGH_SAMPLES_STD));
endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen #(
  parameter int unsigned BAUD_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [BAUD_W-1:0] baud,
  input  logic              fast_mode,
  input  logic              scl_in,
  output logic              scl_pull,
  output logic              period_done,
  output logic              low_fault
);
  logic scl_s;
  logic run;
  logic tick;

  scl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (scl_in),
    .q_sync  (scl_s)
  );

  scl_prescaler #(.BAUD_W(BAUD_W)) u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .baud  (baud),
    .tick  (tick)
  );

  scl_phase_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .tick      (tick),
    .fast_mode (fast_mode),
    .scl_s     (scl_s),
    .run       (run),
    .pull      (scl_pull),
    .done      (period_done),
    .fault     (low_fault)
  );
endmodule

// File: tb/test_scl_phase_gen.sv
module test_scl_phase_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic [7:0] baud = 8'd3;
  logic       fast_mode = 1'b0;
  logic       scl_in;
  logic       scl_pull, period_done, low_fault;

  int stretch_len = 0;
  bit stuck_high  = 1'b0;
  int rel_cnt     = 1000;
  int checks = 0;
  int errors = 0;

  always #5ns clk = ~clk;

  // open-drain line model with an optional client stretch after release
  assign scl_in = stuck_high ? 1'b1 : (!scl_pull && rel_cnt >= stretch_len);
  always @(posedge clk) rel_cnt <= scl_pull ? 0 : (rel_cnt < 1000 ? rel_cnt + 1 : rel_cnt);

  scl_phase_gen i_scl_phase_gen (
    .clk(clk), .rst_n(rst_n), .enable(enable), .baud(baud),
    .fast_mode(fast_mode), .scl_in(scl_in), .scl_pull(scl_pull),
    .period_done(period_done), .low_fault(low_fault)
  );

  // baud, fast, stretch cycles, expected period cycles
  localparam int VEC [8][4] = '{
    '{7, 0, 0, 40}, '{7, 1, 0, 32}, '{1, 0, 0, 10}, '{3, 1, 0, 16},
    '{3, 0, 10, 32}, '{3, 1, 10, 28}, '{7, 0, 20, 56}, '{2, 1, 2, 12}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_done(output int n, output int p, output int f);
    n = 0; p = 0; f = 0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      n++;
      if (scl_pull)  p++;
      if (low_fault) f++;
      if (period_done) break;
    end
  endtask

  initial begin
    #1_000_000ns;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n, p, f, b;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(!scl_pull && !period_done && !low_fault, "R8 reset outputs", scl_pull, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!scl_pull && !period_done && !low_fault, "R8 after reset idle", scl_pull, 0);

    for (int v = 0; v < 8; v++) begin
      enable = 1'b0;
      repeat (3) @(negedge clk);
      baud = 8'(VEC[v][0]); fast_mode = VEC[v][1][0]; stretch_len = VEC[v][2];
      b = VEC[v][0] + 1;
      enable = 1'b1;
      wait_done(n, p, f);
      chk(n == VEC[v][3], $sformatf("R1 R2 R4 first period vec %0d", v), n, VEC[v][3]);
      wait_done(n, p, f);
      chk(n == VEC[v][3], $sformatf("R2 R4 period vec %0d", v), n, VEC[v][3]);
      chk(p == 2 * b, $sformatf("R3 pull cycles vec %0d", v), p, 2 * b);
      chk(f == 0, $sformatf("R5 no fault vec %0d", v), f, 0);
      @(negedge clk);
      chk(!period_done && scl_pull, $sformatf("R6 strobe one cycle then pull vec %0d", v),
          {period_done, scl_pull}, 1);
    end

    // R5: line stuck high, fault each period, length unchanged
    enable = 1'b0; repeat (3) @(negedge clk);
    baud = 8'd3; fast_mode = 1'b0; stretch_len = 0; stuck_high = 1'b1;
    enable = 1'b1;
    wait_done(n, p, f);
    wait_done(n, p, f);
    chk(f == 1, "R5 fault pulse count", f, 1);
    chk(n == 20, "R5 period length with fault", n, 20);
    chk(p == 8, "R5 line still released", p, 8);
    stuck_high = 1'b0;

    // R7: stop mid-period, stay quiet, restart from scratch
    repeat (5) @(negedge clk);
    enable = 1'b0;
    repeat (2) @(negedge clk);
    chk(!scl_pull, "R7 released after stop", scl_pull, 0);
    p = 0; f = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (scl_pull || period_done || low_fault) p++;
    end
    chk(p == 0, "R7 quiet while stopped", p, 0);
    baud = 8'd4; fast_mode = 1'b1;
    enable = 1'b1;
    wait_done(n, p, f);
    chk(n == 20, "R7 restart first period", n, 20);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule